// File: doc/BRIEF.md
# Flow-Through Byte-Write SRAM Core

A synchronous single-port memory whose address, control and write data are captured on the rising clock edge, while the read path carries no output register: the word at a captured read address reaches the data outputs in the same cycle, once the array access settles. Each word is made of four nine-bit lanes. Every lane holds eight data bits and one parity bit, which gives 36 bits per word.

Writes go through a layered decode. A global write input stores every lane. Below it, a byte-write enable hands control to one select per lane, and any mix of lanes can be stored in a single cycle. A captured write is committed to the array on the following clock edge. A read captured on that same edge therefore already returns the new word.

The output enable acts asynchronously. A chip-enable deselect takes effect in the cycle right after it is sampled. A sleep input turns the outputs off at once, makes the block ignore accesses, and keeps the stored contents. The bidirectional bus is modelled as separate write-data, read-data and drive-enable signals. Burst address sequencing is handled by a separate block.

Top module: `sram_ft_core`

## Requirements
- R1: While `rst_ni` is low, `oe_o` is 0 and `data_o` is all zeros.
- R2: A read captured at a clock edge puts the addressed word on `data_o` with `oe_o` high in the same cycle, before the next edge (no output register).
- R3: With `gw_ni` low at a selected edge, all four lanes are written, whatever `bwe_ni` and `bw_ni` hold.
- R4: With `gw_ni` high and `bwe_ni` low, lane i (bits 9i+8..9i, parity in bit 9i+8) is written exactly when `bw_ni[i]` is low. Any combination of lanes may be written in one cycle, and unselected lanes keep their contents.
- R5: With `gw_ni` high and either `bwe_ni` high or all of `bw_ni` high, the cycle is a read and the array is left unchanged.
- R6: While `oe_ni` is high, `oe_o` is 0 and `data_o` is zero, and this follows `oe_ni` without waiting for a clock edge, even during a read.
- R7: During the cycle of a captured write, `oe_o` is 0 whatever `oe_ni` holds.
- R8: With `ce_ni` high at an edge, the following cycle is deselected: `oe_o` is 0 and nothing is written.
- R9: While `sleep_i` is high, `oe_o` is 0 at once, accesses sampled at edges are ignored (no write, no read), and the array contents are kept.
- R10: A write followed immediately by a read of the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the control registers |
| addr_i | input | ADDR_W | Word address, sampled on the rising edge |
| ce_ni | input | 1 | Chip enable, active low, sampled |
| gw_ni | input | 1 | Global write, active low: writes all lanes |
| bwe_ni | input | 1 | Byte-write enable, active low: hands control to the lane selects |
| bw_ni | input | LANES | Per-lane write select, active low |
| wdata_i | input | LANES*LANE_W | Write data, sampled with the address |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Low-power request, active high |
| data_o | output | LANES*LANE_W | Read data, zero when not driving |
| oe_o | output | 1 | Bus drive enable for the read data |

## Verification
A wrong lane decode shows up as a mixed word. The bad lanes only appear when that address is read, which can be the very next cycle, so the bench reads every written word back right away and compares all four lanes against a model built from the decode rules. A stuck access-type register shows up in the same cycle as `oe_o` high during a write, or as `oe_o` low during a read. A deselect or sleep that fails to block a write is hidden until the damaged address is read after the condition ends, so those tests always end with that read-back.

// File: rtl/sram_ft_pkg.sv
package sram_ft_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sram_ft_wdec.sv
module sram_ft_wdec #(
  parameter int unsigned LANES = 4
) (
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  output logic [LANES-1:0] lane_we_o,
  output logic             wr_o
);
  // global write overrides; byte-write enable gates per-lane selects
  always_comb begin
    if (!gw_ni)       lane_we_o = '1;
    else if (!bwe_ni) lane_we_o = ~bw_ni;
    else              lane_we_o = '0;
  end

  assign wr_o = |lane_we_o;
endmodule

// File: rtl/sram_ft_capture.sv
module sram_ft_capture
  import sram_ft_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              sleep_i,
  input  logic              gw_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic [WORD_W-1:0] wdata_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  lane_we_o,
  output logic [WORD_W-1:0] wdata_o
);
  logic [LANES-1:0] lane_we_d;
  logic             wr_d;
  logic             accept;

  sram_ft_wdec #(.LANES(LANES)) i_wdec (
    .gw_ni    (gw_ni),
    .bwe_ni   (bwe_ni),
    .bw_ni    (bw_ni),
    .lane_we_o(lane_we_d),
    .wr_o     (wr_d)
  );

  assign accept = !ce_ni && !sleep_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o      <= OP_IDLE;
      addr_o    <= '0;
      lane_we_o <= '0;
      wdata_o   <= '0;
    end else if (accept) begin
      op_o      <= wr_d ? OP_WRITE : OP_READ;
      addr_o    <= addr_i;
      lane_we_o <= lane_we_d;
      wdata_o   <= wdata_i;
    end else begin
      op_o      <= OP_IDLE;
      lane_we_o <= '0;
    end
  end

  p_gw_all_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !gw_ni) |=> (op_o == OP_WRITE && (&lane_we_o)));

  p_lane_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && gw_ni && !bwe_ni && !(&bw_ni)) |=>
      (op_o == OP_WRITE && lane_we_o == ~$past(bw_ni)));

  p_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && gw_ni && (bwe_ni || (&bw_ni))) |=>
      (op_o == OP_READ && lane_we_o == '0));

  p_desel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> (op_o == OP_IDLE && lane_we_o == '0));

  p_sleep_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (op_o == OP_IDLE));
endmodule

// File: rtl/sram_ft_array.sv
module sram_ft_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DEPTH  = 1 << ADDR_W,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic [LANES-1:0]  we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[l]) mem_q[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    // unregistered read: same address register feeds both ports
    assign rdata_o[l*LANE_W +: LANE_W] = mem_q[addr_i];
  end
endmodule

// File: rtl/sram_ft_outdrv.sv
module sram_ft_outdrv
  import sram_ft_pkg::*;
#(
  parameter int unsigned WORD_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic              oe_ni,
  input  logic              sleep_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] data_o,
  output logic              oe_o
);
  assign oe_o   = (op_i == OP_READ) && !oe_ni && !sleep_i;
  assign data_o = oe_o ? rdata_i : '0;

  p_oe_async_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (!oe_o && data_o == '0));

  p_wr_hiz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_WRITE) |-> !oe_o);

  p_sleep_hiz_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !oe_o);
endmodule

// File: rtl/sram_ft_core.sv
module sram_ft_core
  import sram_ft_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              gw_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              oe_ni,
  input  logic              sleep_i,
  output logic [WORD_W-1:0] data_o,
  output logic              oe_o
);
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  lane_we_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] rdata;
  logic [LANES-1:0]  arr_we;

  sram_ft_capture #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .ce_ni    (ce_ni),
    .sleep_i  (sleep_i),
    .gw_ni    (gw_ni),
    .bwe_ni   (bwe_ni),
    .bw_ni    (bw_ni),
    .wdata_i  (wdata_i),
    .op_o     (op_q),
    .addr_o   (addr_q),
    .lane_we_o(lane_we_q),
    .wdata_o  (wdata_q)
  );

  // captured write commits on the following edge
  assign arr_we = (op_q == OP_WRITE) ? lane_we_q : '0;

  sram_ft_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
    .clk_i  (clk_i),
    .we_i   (arr_we),
    .addr_i (addr_q),
    .wdata_i(wdata_q),
    .rdata_o(rdata)
  );

  sram_ft_outdrv #(.WORD_W(WORD_W)) i_outdrv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op_q),
    .oe_ni  (oe_ni),
    .sleep_i(sleep_i),
    .rdata_i(rdata),
    .data_o (data_o),
    .oe_o   (oe_o)
  );

  p_rst_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!oe_o && data_o == '0));

  p_no_wr_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q != OP_WRITE) |-> (arr_we == '0));
endmodule

// File: tb/test_sram_ft_core.sv
`timescale 1ns/1ps
module test_sram_ft_core;
  localparam int unsigned AW = 6;
  localparam int unsigned WW = 36;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ce_ni = 1'b1, gw_ni = 1'b1, bwe_ni = 1'b1, oe_ni = 1'b0, sleep = 1'b0;
  logic [3:0]    bw_ni = 4'hF;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] data_o;
  logic          oe_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [WW-1:0] model [1 << AW];

  always #10 clk = ~clk;

  sram_ft_core i_sram_ft_core (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .ce_ni(ce_ni), .gw_ni(gw_ni),
    .bwe_ni(bwe_ni), .bw_ni(bw_ni), .wdata_i(wdata), .oe_ni(oe_ni),
    .sleep_i(sleep), .data_o(data_o), .oe_o(oe_o)
  );

  typedef struct packed {
    logic          gw_n;
    logic          bwe_n;
    logic [3:0]    bw_n;
    logic [5:0]    a;
    logic [35:0]   wd;
    logic          exp_oe;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 4'hF, 6'd3,  36'h123456789, 1'b0},  // R3 R7 write all
    '{1'b0, 1'b0, 4'h0, 6'd5,  36'hFEDCBA987, 1'b0},  // R3 write all
    '{1'b1, 1'b1, 4'hF, 6'd3,  36'h000000000, 1'b1},  // R2 read
    '{1'b1, 1'b1, 4'h0, 6'd5,  36'h000000000, 1'b1},  // R2 R5 read, selects ignored
    '{1'b0, 1'b1, 4'hF, 6'd3,  36'hAAAAAAAAA, 1'b0},  // R3 gw overrides
    '{1'b1, 1'b1, 4'hF, 6'd3,  36'h000000000, 1'b1},  // R10 read back
    '{1'b1, 1'b0, 4'hA, 6'd5,  36'h111111111, 1'b0},  // R4 lanes 0 and 2
    '{1'b1, 1'b1, 4'hF, 6'd5,  36'h000000000, 1'b1},  // R4 R10 read
    '{1'b1, 1'b0, 4'hF, 6'd5,  36'h333333333, 1'b1},  // R5 bwe low, no select
    '{1'b1, 1'b0, 4'h7, 6'd3,  36'h800000000, 1'b0},  // R4 lane 3 only
    '{1'b1, 1'b1, 4'hF, 6'd3,  36'h000000000, 1'b1},  // R4 R10 read
    '{1'b1, 1'b1, 4'hF, 6'd5,  36'h000000000, 1'b1},  // R5 array unchanged
    '{1'b1, 1'b0, 4'h6, 6'd5,  36'h0F0F0F0F0, 1'b0}   // R4 lanes 0 and 3
  };

  task automatic check(string req, logic [WW-1:0] act, logic [WW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] lanes_of(logic gw_n, logic bwe_n, logic [3:0] bw_n);
    if (!gw_n) return 4'hF;
    if (!bwe_n) return ~bw_n;
    return 4'h0;
  endfunction

  task automatic model_write(logic [AW-1:0] a, logic [3:0] ln, logic [WW-1:0] d);
    for (int l = 0; l < 4; l++)
      if (ln[l]) model[a][l*9 +: 9] = d[l*9 +: 9];
  endtask

  task automatic drive(logic ce_n, logic gw_n, logic bwe_n, logic [3:0] bw_n,
                       logic [AW-1:0] a, logic [WW-1:0] d);
    @(negedge clk);
    ce_ni = ce_n; gw_ni = gw_n; bwe_ni = bwe_n; bw_ni = bw_n; addr = a; wdata = d;
    @(posedge clk);
    #5;
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #5;
    check("R1 oe", {35'd0, oe_o}, '0);
    check("R1 data", data_o, '0);
    @(negedge clk);
    rst_ni = 1'b1;

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [3:0] ln;
      ln = lanes_of(VEC[v].gw_n, VEC[v].bwe_n, VEC[v].bw_n);
      drive(1'b0, VEC[v].gw_n, VEC[v].bwe_n, VEC[v].bw_n, VEC[v].a, VEC[v].wd);
      check($sformatf("R2/R7 oe vec %0d", v), {35'd0, oe_o}, {35'd0, VEC[v].exp_oe});
      if (ln == 4'h0)
        check($sformatf("R2/R4/R5 data vec %0d", v), data_o, model[VEC[v].a]);
      else
        model_write(VEC[v].a, ln, VEC[v].wd);
    end

    // R10 read of lane-0/3 write from last vector
    drive(1'b0, 1'b1, 1'b1, 4'hF, 6'd5, '0);
    check("R10 data", data_o, model[5]);

    // R6 asynchronous output enable
    #2 oe_ni = 1'b1;
    #1;
    check("R6 oe off", {35'd0, oe_o}, '0);
    check("R6 data off", data_o, '0);
    oe_ni = 1'b0;
    #1;
    check("R6 oe back", {35'd0, oe_o}, 36'd1);
    check("R6 data back", data_o, model[5]);

    // R7 write with oe_ni low
    drive(1'b0, 1'b0, 1'b1, 4'hF, 6'd9, 36'h5A5A5A5A5);
    check("R7 write hiz", {35'd0, oe_o}, '0);
    model_write(6'd9, 4'hF, 36'h5A5A5A5A5);

    // R8 deselect blocks a write
    drive(1'b1, 1'b0, 1'b0, 4'h0, 6'd3, 36'h000000000);
    check("R8 deselect oe", {35'd0, oe_o}, '0);
    drive(1'b0, 1'b1, 1'b1, 4'hF, 6'd3, '0);
    check("R8 no write", data_o, model[3]);

    // R9 sleep
    drive(1'b0, 1'b1, 1'b1, 4'hF, 6'd9, '0);
    check("R9 pre-sleep read", data_o, model[9]);
    #1 sleep = 1'b1;
    #1;
    check("R9 sleep oe", {35'd0, oe_o}, '0);
    drive(1'b0, 1'b0, 1'b1, 4'hF, 6'd9, 36'hDEADBEEF0);
    check("R9 write ignored oe", {35'd0, oe_o}, '0);
    drive(1'b0, 1'b1, 1'b1, 4'hF, 6'd9, '0);
    check("R9 read ignored", {35'd0, oe_o}, '0);
    @(negedge clk) sleep = 1'b0;
    drive(1'b0, 1'b1, 1'b1, 4'hF, 6'd9, '0);
    check("R9 contents kept", data_o, model[9]);
    drive(1'b0, 1'b1, 1'b1, 4'hF, 6'd3, '0);
    check("R9 other word kept", data_o, model[3]);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule